// File: doc/BRIEF.md
# Shared Doorbell Interrupt Register Bank

This block turns single 32-bit writes into interrupt requests. A requester writes one word to a write-only index register. Two fields of that word pick one of eight 32-bit message banks and one bit inside the chosen bank. The block ORs that bit into the bank and raises the bank's interrupt output. Software services a bank by reading its message register, which returns the pending bits and empties the bank in the same access. A summary register shows which banks hold pending bits, and reading it clears nothing.

The block decodes a 0x200-byte window over a plain 32-bit register bus. Writes and reads have separate address buses, so an index write and a clearing read can occur in the same cycle. Every access is a full 32-bit word. There is no back-pressure and no valid/ready handshake: the block accepts each access in the cycle it is presented. Read data is registered. It appears on `rd_data` in the cycle after `rd_en`, and it holds that value until the next read.

Top module: `doorbell_bank`

## Requirements
- R1: An access whose address has a nonzero value in bits 3:0 is rejected. A rejected write changes no bank. A rejected read returns 0xFFFFFFFF and clears nothing.
- R2: A write to offset 0x140 uses write-data bits 31:29 as the bank number b and bits 28:24 as the bit position k. It sets bit k of bank b, and bits that are already set stay set. Write-data bits 23:0 are ignored.
- R3: `irq[b]` is high from the cycle after the write that makes bank b nonzero. It stays high while bank b is nonzero and is low again in the cycle after the read that clears bank b.
- R4: A read at offset n*0x10 (n from 0 to 7) returns bank n's value on `rd_data` in the next cycle and leaves bank n at zero.
- R5: A read at offset 0x120 returns, in bits 7:0, one bit per bank (bit n is 1 when bank n is nonzero), with bits 31:8 at zero. It clears no bank.
- R6: A write to any aligned offset other than 0x140 changes no bank.
- R7: An index write and a clearing read of the same bank in one cycle return the old bank value, and the bank then holds only the newly written bit.
- R8: A read at an aligned offset that is neither a bank, the summary nor a misaligned address (0x80 to 0x110, and 0x130 to 0x1F0, including 0x140) returns zero.
- R9: A synchronous active-high `rst` clears every bank, every `irq` bit and `rd_data` to zero.
- R10: `rd_data` changes only in the cycle after a cycle in which `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | 9 | Byte offset of the write within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Byte offset of the read within the window |
| rd_en | input | 1 | Read strobe; reading a bank clears it |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 8 | One level interrupt per bank, high while the bank is nonzero |

## Verification
A wrong bank state shows on `irq` in the very next cycle, because each line is a plain OR-reduction of its bank. A summary read exposes every bank on `rd_data` one cycle later without disturbing any of them. A lost or stray bit shows on the next clearing read of that bank. A missed clear shows as an `irq` that stays high, or as a nonzero value on a second read. The sweep sets every bit of every bank once, so a mis-decoded bank or bit field appears within two cycles of the write that exercises it.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  // Offsets within the window whose values the block's behaviour depends on
  localparam int unsigned INDEX_OFFSET   = 'h140;
  localparam int unsigned SUMMARY_OFFSET = 'h120;
  localparam int unsigned SLOT_SHIFT     = 4;     // banks sit 0x10 apart

  typedef enum logic [2:0] {
    RD_NONE,
    RD_BANK,
    RD_SUMMARY,
    RD_ZERO,
    RD_ERROR
  } rd_kind_e;
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  localparam int SEL_W    = $clog2(NUM_BANKS),
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_en,
  output logic                 set_en,
  output logic [SEL_W-1:0]     set_bank,
  output logic [BIT_W-1:0]     set_bit,
  output logic [NUM_BANKS-1:0] clr_vec,
  output rd_kind_e             rd_kind,
  output logic [SEL_W-1:0]     rd_bank
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;
  localparam int LOW_W  = DATA_W - SEL_W - BIT_W;
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(INDEX_OFFSET);
  localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(SUMMARY_OFFSET);
  localparam logic [SLOT_W-1:0] NB_SLOT = SLOT_W'(NUM_BANKS);

  logic [SLOT_W-1:0] rd_slot;
  logic              rd_aligned;
  logic              unused_low;

  assign rd_slot    = rd_addr[ADDR_W-1:SLOT_SHIFT];
  assign rd_aligned = (rd_addr[SLOT_SHIFT-1:0] == '0);
  assign unused_low = ^wr_data[LOW_W-1:0];

  // Index write: the aligned index offset only; bank and bit come from the top fields
  assign set_en   = wr_en && (wr_addr == IDX_A);
  assign set_bank = wr_data[DATA_W-1 -: SEL_W];
  assign set_bit  = wr_data[DATA_W-1-SEL_W -: BIT_W];
  assign rd_bank  = rd_slot[SEL_W-1:0];

  always_comb begin
    if (!rd_en)                     rd_kind = RD_NONE;
    else if (!rd_aligned)           rd_kind = RD_ERROR;
    else if (rd_slot < NB_SLOT)     rd_kind = RD_BANK;
    else if (rd_addr == SUM_A)      rd_kind = RD_SUMMARY;
    else                            rd_kind = RD_ZERO;
  end

  always_comb begin
    clr_vec = '0;
    if (rd_kind == RD_BANK) clr_vec[rd_bank] = 1'b1;
  end
endmodule

// File: rtl/doorbell_slot.sv
module doorbell_slot #(
  parameter int DATA_W = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [BIT_W-1:0]  set_bit,
  input  logic              clr_en,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] base;

  assign set_mask = set_en ? (DATA_W'(1) << set_bit) : '0;
  // A clearing read empties the old contents; a bit set in the same cycle survives
  assign base     = clr_en ? '0 : value;

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= base | set_mask;
  end

  AST_SET_BIT_LANDS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> value[$past(set_bit)]); // R2
  AST_OLD_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_en) |=> ((value & $past(value)) == $past(value))); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> (value == '0)); // R4
  AST_MERGE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_en) |=> ($countones(value) == 1)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && !set_en) |=> $stable(value)); // R6
endmodule

// File: rtl/doorbell_readmux.sv
module doorbell_readmux
  import doorbell_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  localparam int SEL_W    = $clog2(NUM_BANKS)
) (
  input  logic [DATA_W-1:0] banks [NUM_BANKS],
  input  rd_kind_e          rd_kind,
  input  logic [SEL_W-1:0]  rd_bank,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_next
);
  assign rd_load = (rd_kind != RD_NONE);

  always_comb begin
    rd_next = '0;
    case (rd_kind)
      RD_BANK:    rd_next = banks[rd_bank];
      RD_SUMMARY: for (int i = 0; i < NUM_BANKS; i++) rd_next[i] = |banks[i];
      RD_ERROR:   rd_next = '1;
      default:    rd_next = '0;
    endcase
  end
endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank
  import doorbell_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  localparam int SEL_W    = $clog2(NUM_BANKS),
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_BANKS-1:0] irq
);
  localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(SUMMARY_OFFSET);

  logic                 set_en;
  logic [SEL_W-1:0]     set_bank;
  logic [BIT_W-1:0]     set_bit;
  logic [NUM_BANKS-1:0] clr_vec;
  rd_kind_e             rd_kind;
  logic [SEL_W-1:0]     rd_bank;
  logic [DATA_W-1:0]    banks [NUM_BANKS];
  logic                 rd_load;
  logic [DATA_W-1:0]    rd_next;

  doorbell_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_decode (
    .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_en(rd_en),
    .set_en(set_en), .set_bank(set_bank), .set_bit(set_bit),
    .clr_vec(clr_vec), .rd_kind(rd_kind), .rd_bank(rd_bank)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
    doorbell_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst),
      .set_en(set_en && (set_bank == SEL_W'(g))),
      .set_bit(set_bit),
      .clr_en(clr_vec[g]),
      .value(banks[g])
    );
    assign irq[g] = |banks[g];
  end

  doorbell_readmux #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_readmux (
    .banks(banks), .rd_kind(rd_kind), .rd_bank(rd_bank),
    .rd_load(rd_load), .rd_next(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_load) rd_data <= rd_next;
  end

  AST_MISALIGNED_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr[3:0] != 4'h0) |=> (rd_data == '1)); // R1
  AST_MISALIGNED_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr[3:0] != 4'h0 && !wr_en) |=> $stable(irq)); // R1
  AST_SUMMARY_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == SUM_A && !wr_en) |=> $stable(irq)); // R5
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10
  AST_INDEX_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    set_en |=> irq[$past(set_bank)]); // R3
endmodule

// File: tb/doorbell_bank_test.sv
module doorbell_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [8:0]  rd_addr = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  doorbell_bank uut (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_word(input int b, input int k);
    return {3'(b), 5'(k), 24'hA5C35A};
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wr_rd(input logic [8:0] wa, input logic [31:0] wd,
                       input logic [8:0] ra, output logic [31:0] d);
    @(negedge clk); wr_addr = wa; wr_data = wd; wr_en = 1'b1; rd_addr = ra; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 irq", 32'(irq), 32'h0);
    chk("R9 rd_data", rd_data, 32'h0);
    for (int b = 0; b < 8; b++) begin
      rd(9'(b * 16), v); chk("R9 bank", v, 32'h0);
    end

    // R2/R3/R4 sweep every bank and bit
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 32; k++) begin
        wr(9'h140, idx_word(b, k));
        chk("R3 irq after write", 32'(irq), 32'(8'h1 << b));
        rd(9'(b * 16), v);
        chk("R2 bank value", v, 32'h1 << k);
        chk("R4 irq after clearing read", 32'(irq), 32'h0);
      end
    end

    // R2 accumulation and R5 summary
    for (int b = 0; b < 8; b++) begin
      pat[b] = (32'h1 << b) | (32'h1 << (b + 8)) | (32'h1 << (31 - b));
      wr(9'h140, idx_word(b, b));
      wr(9'h140, idx_word(b, b + 8));
      wr(9'h140, idx_word(b, 31 - b));
      wr(9'h140, idx_word(b, b));
    end
    rd(9'h120, v); chk("R5 summary all", v, 32'hFF);
    rd(9'h120, v); chk("R5 summary does not clear", v, 32'hFF);
    chk("R5 irq kept", 32'(irq), 32'hFF);
    for (int b = 0; b < 8; b++) begin
      rd(9'(b * 16), v); chk("R2 accumulated bits", v, pat[b]);
      rd(9'h120, v); chk("R5 summary partial", v, 32'((9'h1FF << (b + 1)) & 9'h0FF));
    end

    // R10 rd_data holds without rd_en
    wr(9'h140, idx_word(6, 17));
    rd(9'h60, v);
    repeat (5) @(negedge clk);
    chk("R10 rd_data held", rd_data, 32'h1 << 17);

    // R6 writes elsewhere ignored
    for (int o = 0; o < 32; o++) begin
      if (o != 20) wr(9'(o * 16), 32'hFFFF_FFFF);
    end
    chk("R6 irq after stray writes", 32'(irq), 32'h0);
    rd(9'h120, v); chk("R6 summary after stray writes", v, 32'h0);

    // R1 misaligned writes and reads
    for (int l = 1; l < 16; l++) wr(9'(9'h140 + l), idx_word(l % 8, l));
    chk("R1 misaligned write no effect", 32'(irq), 32'h0);
    wr(9'h140, idx_word(0, 3));
    for (int l = 1; l < 16; l++) begin
      rd(9'(l), v); chk("R1 misaligned read all ones", v, 32'hFFFF_FFFF);
    end
    chk("R1 misaligned read kept bank", 32'(irq), 32'h1);
    rd(9'h000, v); chk("R1 bank intact", v, 32'h8);

    // R8 aligned unassigned offsets
    for (int o = 8; o < 32; o++) begin
      if (o != 18) begin
        rd(9'(o * 16), v); chk("R8 unassigned reads zero", v, 32'h0);
      end
    end

    // R7 same-cycle write and clearing read
    wr(9'h140, idx_word(3, 5));
    wr_rd(9'h140, idx_word(3, 9), 9'h30, v);
    chk("R7 read returns old", v, 32'h1 << 5);
    chk("R7 irq still set", 32'(irq), 32'h8);
    rd(9'h30, v); chk("R7 only new bit kept", v, 32'h1 << 9);
    wr(9'h140, idx_word(4, 1));
    wr_rd(9'h140, idx_word(2, 0), 9'h40, v);
    chk("R7 other bank read", v, 32'h2);
    chk("R7 other bank irq", 32'(irq), 32'h4);
    rd(9'h20, v); chk("R7 other bank value", v, 32'h1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule